// File: doc/BRIEF.md
# Byte-Mapped Tick Timekeeper with Alarm

This block keeps time as a free-running 40-bit tick count. A 32768 Hz enable pulse from an oscillator drives it. By default a 5-bit divider turns that pulse into 1024 ticks per second, so a seconds value is the count shifted right by ten. A fast mode skips the divider, and the count then advances on every oscillator pulse. A host reaches the block through a byte-wide register port: one control byte, a 24-bit alarm compare value, and the count bytes. The serial transport that carries those accesses lives outside the block.

Reading a multi-byte count from a counter that keeps running would tear across byte boundaries. To avoid that, a read of the address just below the count bytes freezes a copy of the whole count, and the count addresses then return bytes of that copy. Writes to the count go into a holding register, and the new value takes effect in one step when the least significant byte is written.

The alarm looks only at the low 24 tick bits, which covers about four and a half hours at the normal rate. When those bits move onto the programmed value while the block runs, a sticky interrupt goes high. It stays high until the host writes the alarm or stops the block.

Top module: `tick_timekeeper`

## Requirements
- R1: After reset, the control byte reads 0x00, every alarm byte reads 0x00, a latched count reads 0, and `alarm_irq` is 0.
- R2: Control byte at 0xC0. Bit 6 is the oscillator source, bit 5 is run, bit 4 is the buffer output enable, bit 3 is fast mode, and bits 2:1 are the capacitance code. These bits read back as written, and bit 0 always reads 0. Bit 7 reads 0 after reset, becomes 1 on any write with bit 7 set, and a write with bit 7 clear does not clear it.
- R3: While run (bit 5) is 0, the count keeps its value whatever the oscillator input does.
- R4: With run set and fast mode clear, the count advances once per 32 oscillator pulses. Writing the count clears the divider, so the first advance comes on exactly the 32nd pulse after the load.
- R5: With run and fast mode both set, the count advances by one on each oscillator pulse, and it wraps from all ones to zero.
- R6: A read of 0xC5 returns 0x00 and copies the live count into a snapshot. Reads of 0xC6 to 0xCA return the snapshot bytes, most significant byte first, and they keep returning the same values while the count moves on, until the next read of 0xC5.
- R7: Writes to 0xC6 to 0xC9 only fill a holding register and leave the count unchanged. A write to 0xCA loads the holding bytes plus that byte into the count, whether or not run is set.
- R8: The alarm value occupies 0xC1 to 0xC3, most significant byte first, and reads back as written.
- R9: `alarm_irq` rises one clock after bits 23:0 of the count change to equal the alarm value while run is 1. It does not rise while run is 0.
- R10: Once set, `alarm_irq` stays set until a write to any alarm byte or a clock with run at 0.
- R11: A read of 0xC4 or of any address above 0xCA returns 0x00, and a write to such an address changes no readable state.
- R12: Read data appears on `rdata` one clock after the cycle in which `rd_en` is high, and holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable at the 32768 Hz oscillator rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| alarm_irq | output | 1 | Sticky alarm interrupt |

## Verification
The hardest state to reach is an alarm match inside a long count. At 1024 ticks per second, a match reached by plain counting could be hours away. The stimulus therefore stages a count a few ticks short of the alarm, loads it in one write, and steps it onto the alarm with single oscillator pulses in fast mode. It then checks that the interrupt stays low before the match, rises on it, and clears on each of the two clearing events. For the divider boundary, the bench loads the count in slow mode and checks the count after exactly 31 and 32 pulses.

// File: rtl/tk_pkg.sv
package tk_pkg;
   // Control byte layout; the bit order is what the host decodes.
   typedef struct packed {
      logic       por_seen;   // bit 7
      logic       osc_src;    // bit 6
      logic       run;        // bit 5
      logic       buf_out;    // bit 4
      logic       fast;       // bit 3
      logic [1:0] cap_code;   // bits 2:1
      logic       spare;      // bit 0, always zero
   } tk_ctrl_t;

   localparam int TK_BYTE_W = 8;
endpackage

// File: rtl/tk_regfile.sv
module tk_regfile
   import tk_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BASE_ADDR = 'hC0,
   parameter int ALM_W     = 24,
   parameter int CNT_W     = 40,
   parameter int CNT_OFS   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output tk_ctrl_t          ctrl,
   output logic [ALM_W-1:0]  alarm_val,
   output logic              alarm_wr,
   output logic              load_fire,
   output logic [CNT_W-1:0]  load_val
);
   localparam int ALM_B = ALM_W / TK_BYTE_W;
   localparam int CNT_B = CNT_W / TK_BYTE_W;
   localparam int STG_W = CNT_W - TK_BYTE_W;
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] ALM_A  = ADDR_W'(BASE_ADDR + 1);
   localparam logic [ADDR_W-1:0] ALM_E  = ADDR_W'(BASE_ADDR + ALM_B);
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BASE_ADDR + CNT_OFS + CNT_B - 1);

   logic [STG_W-1:0] stage_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_en && addr == CTRL_A) begin
         ctrl.por_seen <= ctrl.por_seen | wdata[7];
         ctrl.osc_src  <= wdata[6];
         ctrl.run      <= wdata[5];
         ctrl.buf_out  <= wdata[4];
         ctrl.fast     <= wdata[3];
         ctrl.cap_code <= wdata[2:1];
         ctrl.spare    <= 1'b0;
      end
   end

   // Alarm bytes, most significant byte at the lowest address
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alarm_val <= '0;
      end else begin
         for (int b = 0; b < ALM_B; b++) begin
            if (wr_en && addr == ADDR_W'(BASE_ADDR + 1 + b))
               alarm_val[(ALM_B-1-b)*TK_BYTE_W +: TK_BYTE_W] <= wdata;
         end
      end
   end

   // Holding bytes for every count byte except the last one written
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else begin
         for (int i = 0; i < CNT_B - 1; i++) begin
            if (wr_en && addr == ADDR_W'(BASE_ADDR + CNT_OFS + i))
               stage_q[(CNT_B-2-i)*TK_BYTE_W +: TK_BYTE_W] <= wdata;
         end
      end
   end

   assign alarm_wr  = wr_en && (addr >= ALM_A) && (addr <= ALM_E);
   assign load_fire = wr_en && (addr == LAST_A);
   assign load_val  = {stage_q, wdata};
endmodule

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
   parameter int PRE_W = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fast,
   input  logic osc_tick,
   input  logic clr,
   output logic step
);
   logic [PRE_W-1:0] div_q;
   logic             slow_en;

   assign slow_en = run && osc_tick && !fast;

   always_ff @(posedge clk) begin
      if (!rst_n)       div_q <= '0;
      else if (clr)     div_q <= '0;
      else if (slow_en) div_q <= div_q + 1'b1;
   end

   // Slow mode steps when the divider is at its last state and another pulse arrives
   assign step = run && osc_tick && (fast || (&div_q));
endmodule

// File: rtl/tk_counter.sv
module tk_counter #(
   parameter int CNT_W = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             latch,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] snap
);
   always_ff @(posedge clk) begin
      if (!rst_n)     count <= '0;
      else if (load)  count <= load_val;
      else if (step)  count <= count + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     snap <= '0;
      else if (latch) snap <= count;
   end
endmodule

// File: rtl/tk_alarm.sv
module tk_alarm #(
   parameter int ALM_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [ALM_W-1:0] cnt_lo,
   input  logic [ALM_W-1:0] alarm_val,
   input  logic             alarm_wr,
   output logic             irq
);
   logic [ALM_W-1:0] prev_lo;
   logic             hit;

   // A match counts only on the cycle the low bits move onto the alarm value
   assign hit = (cnt_lo == alarm_val) && (cnt_lo != prev_lo);

   always_ff @(posedge clk) begin
      if (!rst_n) prev_lo <= '0;
      else        prev_lo <= cnt_lo;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 irq <= 1'b0;
      else if (alarm_wr || !run)  irq <= 1'b0;
      else if (hit)               irq <= 1'b1;
   end
endmodule

// File: rtl/tick_timekeeper.sv
module tick_timekeeper
   import tk_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BASE_ADDR = 'hC0,
   parameter int ALM_W     = 24,
   parameter int CNT_W     = 40,
   parameter int CNT_OFS   = 6,
   parameter int PRE_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              alarm_irq
);
   localparam int ALM_B = ALM_W / TK_BYTE_W;
   localparam int CNT_B = CNT_W / TK_BYTE_W;
   localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] LATCH_A = ADDR_W'(BASE_ADDR + CNT_OFS - 1);

   generate
      if (CNT_W % TK_BYTE_W != 0) begin : g_bad_cnt
         $error("CNT_W must be a whole number of bytes");
      end
      if (ALM_W % TK_BYTE_W != 0 || ALM_W > CNT_W) begin : g_bad_alm
         $error("ALM_W must be whole bytes and no wider than CNT_W");
      end
      if (CNT_OFS < ALM_B + 2) begin : g_bad_ofs
         $error("CNT_OFS leaves no room for the latch address");
      end
      if (BASE_ADDR + CNT_OFS + CNT_B > (1 << ADDR_W)) begin : g_bad_map
         $error("register map exceeds the address space");
      end
      if (PRE_W < 1) begin : g_bad_pre
         $error("PRE_W must be at least 1");
      end
   endgenerate

   tk_ctrl_t         ctrl_q;
   logic [ALM_W-1:0] alarm_val;
   logic             alarm_wr;
   logic             load_fire;
   logic [CNT_W-1:0] load_val;
   logic             step;
   logic             latch;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] snap;
   logic             run_w;
   logic             fast_w;
   logic [7:0]       rd_mux;

   assign run_w  = ctrl_q.run;
   assign fast_w = ctrl_q.fast;
   assign latch  = rd_en && (addr == LATCH_A);

   tk_regfile #(
      .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .ALM_W(ALM_W),
      .CNT_W(CNT_W), .CNT_OFS(CNT_OFS)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .ctrl(ctrl_q), .alarm_val(alarm_val), .alarm_wr(alarm_wr),
      .load_fire(load_fire), .load_val(load_val)
   );

   tk_prescaler #(.PRE_W(PRE_W)) i_pre (
      .clk(clk), .rst_n(rst_n), .run(run_w), .fast(fast_w),
      .osc_tick(osc_tick), .clr(load_fire), .step(step)
   );

   tk_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .load(load_fire),
      .load_val(load_val), .latch(latch), .count(count), .snap(snap)
   );

   tk_alarm #(.ALM_W(ALM_W)) i_alm (
      .clk(clk), .rst_n(rst_n), .run(run_w), .cnt_lo(count[ALM_W-1:0]),
      .alarm_val(alarm_val), .alarm_wr(alarm_wr), .irq(alarm_irq)
   );

   // Byte views, most significant byte at the lowest address
   logic [7:0] snap_byte [CNT_B];
   logic [7:0] alm_byte  [ALM_B];

   generate
      for (genvar i = 0; i < CNT_B; i++) begin : g_snap_b
         assign snap_byte[i] = snap[(CNT_B-1-i)*TK_BYTE_W +: TK_BYTE_W];
      end
      for (genvar b = 0; b < ALM_B; b++) begin : g_alm_b
         assign alm_byte[b] = alarm_val[(ALM_B-1-b)*TK_BYTE_W +: TK_BYTE_W];
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      if (addr == CTRL_A) rd_mux = ctrl_q;
      for (int b = 0; b < ALM_B; b++) begin
         if (addr == ADDR_W'(BASE_ADDR + 1 + b)) rd_mux = alm_byte[b];
      end
      for (int i = 0; i < CNT_B; i++) begin
         if (addr == ADDR_W'(BASE_ADDR + CNT_OFS + i)) rd_mux = snap_byte[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end
endmodule

// File: rtl/tk_checker.sv
module tk_checker #(
   parameter int CNT_W = 40,
   parameter int ALM_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             osc_tick,
   input logic             run,
   input logic             fast,
   input logic             load_fire,
   input logic [CNT_W-1:0] load_val,
   input logic             latch,
   input logic             alarm_wr,
   input logic [ALM_W-1:0] alarm_val,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] snap,
   input logic             alarm_irq
);
   a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load_fire) |=> $stable(count));

   a_r4_no_pulse_no_move: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_tick && !load_fire) |=> $stable(count));

   a_r5_fast_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && fast && osc_tick && !load_fire) |=> (count == $past(count) + 1'b1));

   a_r6_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !latch |=> $stable(snap));

   a_r7_load_takes_value: assert property (@(posedge clk) disable iff (!rst_n)
      load_fire |=> (count == $past(load_val)));

   a_r9_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_irq) |-> $past(count[ALM_W-1:0] == alarm_val));

   a_r10_cleared_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_wr |=> !alarm_irq);

   a_r10_cleared_by_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !alarm_irq);
endmodule

bind tick_timekeeper tk_checker #(.CNT_W(CNT_W), .ALM_W(ALM_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .run(run_w), .fast(fast_w),
   .load_fire(load_fire), .load_val(load_val), .latch(latch),
   .alarm_wr(alarm_wr), .alarm_val(alarm_val), .count(count), .snap(snap),
   .alarm_irq(alarm_irq)
);

// File: tb/test_tick_timekeeper.sv
module test_tick_timekeeper;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       alarm_irq;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   localparam logic [7:0] A_CTRL = 8'hC0, A_ALM = 8'hC1, A_LATCH = 8'hC5, A_CNT = 8'hC6;
   localparam logic [7:0] RUN = 8'h20, FAST = 8'h08, POR = 8'h80;

   always #4 clk = ~clk;   // 125 MHz

   tick_timekeeper i_tick_timekeeper (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .alarm_irq(alarm_irq)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); osc_tick = 1'b1;
         @(negedge clk); osc_tick = 1'b0;
      end
   endtask

   task automatic load_count(input logic [39:0] v);
      for (int i = 0; i < 5; i++) wr(A_CNT + 8'(i), v[(4-i)*8 +: 8]);
   endtask

   task automatic read_bytes(output logic [39:0] v);
      logic [7:0] b;
      v = '0;
      for (int i = 0; i < 5; i++) begin
         rd(A_CNT + 8'(i), b);
         v = {v[31:0], b};
      end
   endtask

   task automatic read_count(output logic [39:0] v);
      logic [7:0] b;
      rd(A_LATCH, b);
      read_bytes(v);
   endtask

   function automatic logic [39:0] expect_count(logic [39:0] base, bit run, bit fast, int n);
      if (!run) return base;
      return fast ? base + 40'(n) : base + 40'(n / 32);
   endfunction

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin : main
      logic [7:0]  b;
      logic [39:0] c, c2, x;
      int unsigned seed_init;
      seed_init = $urandom(32'd4711);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL, b);   check("R1 ctrl", b, 8'h00);
      for (int i = 0; i < 3; i++) begin
         rd(A_ALM + 8'(i), b); check("R1 alarm byte", b, 8'h00);
      end
      read_count(c);   check("R1 count", c, 40'h0);
      check("R1 irq", alarm_irq, 1'b0);

      // R2 control bits, sticky bit 7
      wr(A_CTRL, 8'h7F); rd(A_CTRL, b); check("R2 bits 6:1, bit0 zero", b, 8'h7E);
      wr(A_CTRL, 8'h00); rd(A_CTRL, b); check("R2 clear", b, 8'h00);
      wr(A_CTRL, 8'h82); rd(A_CTRL, b); check("R2 bit7 set", b, 8'h82);
      wr(A_CTRL, 8'h00); rd(A_CTRL, b); check("R2 bit7 sticky", b, 8'h80);

      // R7 staging then load, run off
      x = 40'h12_3456_789A;
      for (int i = 0; i < 4; i++) wr(A_CNT + 8'(i), x[(4-i)*8 +: 8]);
      read_count(c); check("R7 staged bytes no effect", c, 40'h0);
      wr(A_CNT + 8'd4, x[7:0]);
      read_count(c); check("R7 load on last byte", c, x);

      // R3 stopped counter holds
      pulse(10); read_count(c); check("R3 hold while stopped", c, x);

      // R5 fast mode
      wr(A_CTRL, POR | RUN | FAST);
      pulse(7); read_count(c); check("R5 fast steps", c, x + 40'd7);

      // R6 snapshot coherence
      rd(A_LATCH, b); check("R6 latch read returns zero", b, 8'h00);
      rd(A_CNT, b); rd(A_CNT + 8'd1, b);
      pulse(3);
      read_bytes(c2); check("R6 snapshot frozen", c2, x + 40'd7);
      read_count(c); check("R6 relatch sees new count", c, x + 40'd10);

      // R12 rdata holds between reads
      rd(A_CTRL, b);
      repeat (3) @(negedge clk);
      check("R12 rdata holds", rdata, POR | RUN | FAST);

      // R4 divider boundary, load clears divider
      wr(A_CTRL, POR | RUN);
      pulse(13);
      load_count(40'h0000_0400_00);
      pulse(31); read_count(c); check("R4 31 pulses no step", c, 40'h0000_0400_00);
      pulse(1);  read_count(c); check("R4 32nd pulse steps", c, 40'h0000_0400_01);
      pulse(64); read_count(c); check("R4 64 more pulses", c, 40'h0000_0400_03);

      // R5 wrap
      wr(A_CTRL, POR | RUN | FAST);
      load_count(40'hFF_FFFF_FFFF);
      pulse(1); read_count(c); check("R5 wrap to zero", c, 40'h0);

      // R8 alarm bytes
      wr(A_ALM, 8'h12); wr(A_ALM + 8'd1, 8'h34); wr(A_ALM + 8'd2, 8'h56);
      rd(A_ALM, b);        check("R8 alarm hi", b, 8'h12);
      rd(A_ALM + 8'd1, b); check("R8 alarm mid", b, 8'h34);
      rd(A_ALM + 8'd2, b); check("R8 alarm lo", b, 8'h56);

      // R9 and R10 alarm interrupt
      load_count(40'hAB_0012_3453);
      pulse(2); @(negedge clk); check("R9 no irq before match", alarm_irq, 1'b0);
      pulse(1); @(negedge clk); check("R9 irq on match", alarm_irq, 1'b1);
      pulse(2); @(negedge clk); check("R10 irq sticky", alarm_irq, 1'b1);
      wr(A_ALM + 8'd2, 8'h56); @(negedge clk); check("R10 alarm write clears", alarm_irq, 1'b0);
      load_count(40'h00_0012_3455);
      pulse(1); @(negedge clk); check("R9 irq again", alarm_irq, 1'b1);
      wr(A_CTRL, POR | FAST); @(negedge clk); check("R10 stop clears", alarm_irq, 1'b0);
      load_count(40'h00_0012_3456); @(negedge clk);
      check("R9 no irq while stopped", alarm_irq, 1'b0);

      // R11 unmapped addresses
      wr(8'hC4, 8'hFF); rd(8'hC4, b); check("R11 C4 reads zero", b, 8'h00);
      wr(8'hCB, 8'hFF); rd(8'hCB, b); check("R11 CB reads zero", b, 8'h00);
      rd(A_CTRL, b); check("R11 ctrl untouched", b, POR | FAST);
      read_count(c); check("R11 count untouched", c, 40'h00_0012_3456);

      // Random loads, modes and pulse counts
      for (int it = 0; it < 24; it++) begin
         bit run_r, fast_r;
         int n;
         run_r  = ($urandom % 4) != 0;
         fast_r = $urandom % 2;
         n      = $urandom % 90;
         x = ({10'd0, 30'($urandom)} << 10) | 40'($urandom % 1024);
         wr(A_CTRL, POR | (run_r ? RUN : 8'h00) | (fast_r ? FAST : 8'h00));
         load_count(x);
         pulse(n);
         read_count(c);
         check(run_r ? (fast_r ? "R5 random fast" : "R4 random slow") : "R3 random stopped",
               c, expect_count(x, run_r, fast_r, n));
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule